// File: doc/BRIEF.md
# Pin Bank Controller with Interrupt Detection

This block controls a bank of 32 general-purpose pins through a small register bus of full 32-bit words. Software sets a direction bit per pin. Output pins drive the value held in an output data register, and their output enable follows the direction bit. Input pads pass through a two-stage synchronizer before anything else looks at them. Their sampled levels can be read back, both through a pad status word and through the data word, which merges the driven values with the sampled pad levels.

Each input pin can raise a sticky status bit. A 2-bit mode selects low level, high level, rising edge or falling edge. A separate per-pin override makes the pin respond to a change in either direction. Software clears status bits by writing ones. A mask word selects which status bits drive the single interrupt output. The override word can be removed at build time.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset, the data, direction, both mode words, mask and override words read 0, pad_oe is 0 and irq is 0.
- R2: pad_out equals the data word at offset 0x00. pad_oe equals the direction word at offset 0x04, where bit value 1 makes the pin an output.
- R3: A read at 0x00 returns, bit by bit, the data word bit for output pins and the synchronized pad level for input pins.
- R4: A read at 0x08 returns the synchronized pad levels of input pins, with output-pin bits reading 0. A pad change becomes visible after the second rising clock edge. Writes to 0x08 have no effect.
- R5: The mode of pin n occupies bits 2n+1:2n of a 64-bit field. Offset 0x0C holds pins 0-15 and offset 0x10 holds pins 16-31. The codes are 00 for low level, 01 for high level, 10 for rising edge and 11 for falling edge.
- R6: When bit n of the override word at 0x1C is 1, any change of pin n's synchronized level sets status bit n, whatever its mode.
- R7: A pin whose direction bit is 1 never sets its status bit.
- R8: The status word at 0x18 is sticky. Writing 1 clears a bit, and writing 0 leaves it unchanged. A detection in the same cycle as a clear keeps the bit set, so a level-mode pin that is still active reads 1 right after a clear.
- R9: irq is 1 exactly when some status bit is 1 and the matching bit of the mask word at 0x14 is also 1.
- R10: With HAS_ANYEDGE = 0, offset 0x1C reads 0 and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Driven pad values |
| pad_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined masked interrupt |

## Verification
Two things can fall on the same clock edge: a software clear of a status bit, and a fresh detection on that bit or on a neighbouring one. The bench arranges this by counting clock edges from a pad change, so that a rising-edge detection arrives on exactly the edge where a clear write of the same bit and of an already-set bit takes effect. The check passes only if the detected bit survives and the other bit is cleared. A level-mode pin whose level stays active is cleared and must read back as set again at once.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    RG_DATA  = 3'd0,
    RG_DIR   = 3'd1,
    RG_PAD   = 3'd2,
    RG_CFGLO = 3'd3,
    RG_CFGHI = 3'd4,
    RG_MASK  = 3'd5,
    RG_STS   = 3'd6,
    RG_ANY   = 3'd7
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] addr);
    return reg_sel_e'(addr[ADDR_W-1:2]);
  endfunction
endpackage

// File: rtl/pinbank_rstsync.sv
module pinbank_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      prev <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev <= stage_q[STAGES-1];
    end
  end

  assign cur = stage_q[STAGES-1];
endmodule

// File: rtl/pinbank_detect.sv
module pinbank_detect #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0]   lvl_cur,
  input  logic [NPINS-1:0]   lvl_prev,
  input  logic [NPINS-1:0]   is_out,
  input  logic [2*NPINS-1:0] mode,
  input  logic [NPINS-1:0]   both_edge,
  output logic [NPINS-1:0]   hit
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall;
    assign rise = lvl_cur[i] & ~lvl_prev[i];
    assign fall = ~lvl_cur[i] & lvl_prev[i];

    always_comb begin
      if (is_out[i]) begin
        hit[i] = 1'b0;
      end else if (both_edge[i]) begin
        hit[i] = rise | fall;
      end else if (mode[2*i+1]) begin
        hit[i] = mode[2*i] ? fall : rise;
      end else begin
        hit[i] = mode[2*i] ? lvl_cur[i] : ~lvl_cur[i];
      end
    end
  end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter bit HAS_ANYEDGE = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);
  localparam int CFG_W = 2 * NPINS;

  logic             rst_q_n;
  logic [NPINS-1:0] lvl_cur, lvl_prev, hit;
  logic [NPINS-1:0] data_q, data_d, dir_q, dir_d, mask_q, mask_d;
  logic [NPINS-1:0] status_q, status_d, any_q;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             wr_en;
  reg_sel_e         sel;

  pinbank_rstsync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  pinbank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .async_in (pad_in),
    .cur      (lvl_cur),
    .prev     (lvl_prev)
  );

  pinbank_detect #(.NPINS(NPINS)) u_det (
    .lvl_cur   (lvl_cur),
    .lvl_prev  (lvl_prev),
    .is_out    (dir_q),
    .mode      (cfg_q),
    .both_edge (any_q),
    .hit       (hit)
  );

  assign wr_en = bus_sel & bus_wr;
  assign sel   = decode_sel(bus_addr);

  // next-state for the configuration and status words
  always_comb begin
    data_d   = data_q;
    dir_d    = dir_q;
    mask_d   = mask_q;
    cfg_d    = cfg_q;
    status_d = status_q;
    if (wr_en) begin
      case (sel)
        RG_DATA:  data_d = bus_wdata;
        RG_DIR:   dir_d  = bus_wdata;
        RG_CFGLO: cfg_d[NPINS-1:0]     = bus_wdata;
        RG_CFGHI: cfg_d[CFG_W-1:NPINS] = bus_wdata;
        RG_MASK:  mask_d = bus_wdata;
        RG_STS:   status_d = status_q & ~bus_wdata;
        default:  ;
      endcase
    end
    status_d = status_d | hit;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      mask_q   <= '0;
      cfg_q    <= '0;
      status_q <= '0;
    end else begin
      data_q   <= data_d;
      dir_q    <= dir_d;
      mask_q   <= mask_d;
      cfg_q    <= cfg_d;
      status_q <= status_d;
    end
  end

  if (HAS_ANYEDGE) begin : g_any
    logic any_en;
    assign any_en = wr_en & (sel == RG_ANY);
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n)    any_q <= '0;
      else if (any_en) any_q <= bus_wdata;
    end
  end else begin : g_no_any
    assign any_q = '0;
  end

  always_comb begin
    case (sel)
      RG_DATA:  bus_rdata = (data_q & dir_q) | (lvl_cur & ~dir_q);
      RG_DIR:   bus_rdata = dir_q;
      RG_PAD:   bus_rdata = lvl_cur & ~dir_q;
      RG_CFGLO: bus_rdata = cfg_q[NPINS-1:0];
      RG_CFGHI: bus_rdata = cfg_q[CFG_W-1:NPINS];
      RG_MASK:  bus_rdata = mask_q;
      RG_STS:   bus_rdata = status_q;
      RG_ANY:   bus_rdata = any_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign pad_out = data_q;
  assign pad_oe  = dir_q;
  assign irq     = |(status_q & mask_q);
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [4:0]       bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] pad_oe,
  input logic             irq,
  input logic [NPINS-1:0] dir_q,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] status_q
);
  logic             dir_wr;
  logic [NPINS-1:0] clr_bits;

  assign dir_wr   = bus_sel && bus_wr && (bus_addr[4:2] == 3'd1);
  assign clr_bits = (bus_sel && bus_wr && (bus_addr[4:2] == 3'd6)) ? bus_wdata : '0;

  // R2: a direction write shows on the enables one edge later
  a_r2_oe_after_write: assert property (@(posedge clk) disable iff (!rst_q_n)
    dir_wr |=> (pad_oe == $past(bus_wdata)));

  // R7: new status bits only appear on pins that were inputs
  a_r7_no_set_on_output: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> ((status_q & ~$past(status_q) & $past(dir_q)) == '0));

  // R8: a status bit only falls when software wrote 1 to it
  a_r8_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> (($past(status_q) & ~status_q & ~$past(clr_bits)) == '0));

  // R9: with every mask bit at 0 the interrupt stays low
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mask_q == '0) |-> !irq);

  // R9: a raised interrupt implies a set status bit
  a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq |-> (status_q != '0));
endmodule

bind pinbank_ctrl pinbank_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pad_oe    (pad_oe),
  .irq       (irq),
  .dir_q     (dir_q),
  .mask_q    (mask_q),
  .status_q  (status_q)
);

// File: tb/sim_pinbank_ctrl.sv
`timescale 1ns/1ps
module sim_pinbank_ctrl;
  localparam logic [4:0] A_DATA = 5'h00, A_DIR = 5'h04, A_PAD = 5'h08,
    A_CLO = 5'h0C, A_CHI = 5'h10, A_MASK = 5'h14, A_STS = 5'h18, A_ANY = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata0, rdata1, pad_in, pad_out, pad_oe, pad_out1, pad_oe1;
  logic        irq, irq1;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pinbank_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  pinbank_ctrl #(.HAS_ANYEDGE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
    .pad_in(pad_in), .pad_out(pad_out1), .pad_oe(pad_oe1), .irq(irq1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = rdata0;
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sts_is(input string req, input logic [31:0] exp);
    logic [31:0] v;
    rd(A_STS, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_DATA, v); check("R1 data", v & ~pad_in, 32'h0);
    rd(A_DIR, v);  check("R1 dir", v, 32'h0);
    rd(A_CLO, v);  check("R1 cfg lo", v, 32'h0);
    rd(A_CHI, v);  check("R1 cfg hi", v, 32'h0);
    rd(A_MASK, v); check("R1 mask", v, 32'h0);
    rd(A_ANY, v);  check("R1 any", v, 32'h0);
    check("R1 oe", pad_oe, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    wr(A_STS, 32'hFFFF_FFFF);
    sts_is("R8 clear all", 32'h0);
  endtask

  task automatic t_outputs();
    logic [31:0] v;
    wr(A_DIR, 32'h0000_00FF);
    wr(A_DATA, 32'hA5A5_A5A5);
    check("R2 pad_out", pad_out, 32'hA5A5_A5A5);
    check("R2 pad_oe", pad_oe, 32'h0000_00FF);
    rd(A_DATA, v); check("R3 data merge", v, 32'hFFFF_FFA5);
    rd(A_PAD, v);  check("R4 pad read", v, 32'hFFFF_FF00);
    wr(A_PAD, 32'h0);
    rd(A_PAD, v);  check("R4 pad write ignored", v, 32'hFFFF_FF00);
    wr(A_CLO, 32'h00E4_0000);   // pin9 high, pin10 rising, pin11 falling
    wr(A_CHI, 32'h0000_0200);   // pin20 rising
    @(negedge clk); pad_in[9] = 1'b0;
    settle();
    wr(A_STS, 32'hFFFF_FFFF);
    sts_is("R8 quiet start", 32'h0);
    @(negedge clk); pad_in[8] = 1'b0;
    @(posedge clk); @(negedge clk);
    bus_addr = A_PAD; #1 check("R4 one edge old", rdata0 & 32'h100, 32'h100);
    @(posedge clk); @(negedge clk);
    bus_addr = A_PAD; #1 check("R4 two edges new", rdata0 & 32'h100, 32'h0);
    settle();
    sts_is("R5 low level pin8", 32'h0000_0100);
    pad_in[8] = 1'b1;
    settle();
    wr(A_STS, 32'h0000_0100);
    sts_is("R8 cleared pin8", 32'h0);
    wr(A_STS, 32'h0);
    sts_is("R8 zero write", 32'h0);
  endtask

  task automatic t_modes();
    @(negedge clk); pad_in[9] = 1'b1; settle();
    sts_is("R5 high level pin9", 32'h0000_0200);
    wr(A_STS, 32'h0000_0200);
    sts_is("R8 level resets", 32'h0000_0200);
    @(negedge clk); pad_in[9] = 1'b0; settle();
    wr(A_STS, 32'h0000_0200);
    @(negedge clk); pad_in[10] = 1'b0; settle();
    sts_is("R5 rising ignores fall", 32'h0);
    @(negedge clk); pad_in[10] = 1'b1; settle();
    sts_is("R5 rising pin10", 32'h0000_0400);
    wr(A_STS, 32'h0000_0400);
    @(negedge clk); pad_in[11] = 1'b0; settle();
    sts_is("R5 falling pin11", 32'h0000_0800);
    wr(A_STS, 32'h0000_0800);
    @(negedge clk); pad_in[11] = 1'b1; settle();
    sts_is("R5 falling ignores rise", 32'h0);
    @(negedge clk); pad_in[20] = 1'b0; settle();
    @(negedge clk); pad_in[20] = 1'b1; settle();
    sts_is("R5 upper word pin20", 32'h0010_0000);
    wr(A_STS, 32'h0010_0000);
  endtask

  task automatic t_irq();
    wr(A_MASK, 32'h0000_0400);
    @(negedge clk); pad_in[11] = 1'b0; settle();
    check("R9 masked source", {31'h0, irq}, 32'h0);
    @(negedge clk); pad_in[10] = 1'b0; settle();
    @(negedge clk); pad_in[10] = 1'b1; settle();
    check("R9 unmasked source", {31'h0, irq}, 32'h1);
    wr(A_STS, 32'h0000_0400);
    check("R9 after clear", {31'h0, irq}, 32'h0);
    sts_is("R9 other bit kept", 32'h0000_0800);
    // R8 clear coinciding with detection of pin10 rising
    @(negedge clk); pad_in[10] = 1'b0; settle();
    @(negedge clk); pad_in[10] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(A_STS, 32'h0000_0C00);
    sts_is("R8 set beats clear", 32'h0000_0400);
    @(negedge clk); pad_in[11] = 1'b1;
    wr(A_MASK, 32'h0);
    wr(A_STS, 32'hFFFF_FFFF);
  endtask

  task automatic t_anyedge();
    logic [31:0] v;
    wr(A_ANY, 32'h0000_0400);
    rd(A_ANY, v); check("R6 readback", v, 32'h0000_0400);
    @(negedge clk); pad_in[10] = 1'b0; settle();
    sts_is("R6 fall on rising pin", 32'h0000_0400);
    wr(A_STS, 32'h0000_0400);
    @(negedge clk); pad_in[10] = 1'b1; settle();
    sts_is("R6 rise", 32'h0000_0400);
    wr(A_STS, 32'h0000_0400);
    wr(A_ANY, 32'h0);
  endtask

  task automatic t_output_pin();
    @(negedge clk); pad_in[3] = 1'b0; settle();
    @(negedge clk); pad_in[3] = 1'b1; settle();
    @(negedge clk); pad_in[3] = 1'b0; settle();
    sts_is("R7 output pin quiet", 32'h0);
    @(negedge clk); pad_in[3] = 1'b1; settle();
  endtask

  task automatic t_no_any();
    wr(A_ANY, 32'hFFFF_FFFF);
    @(negedge clk); bus_addr = A_ANY;
    #1 check("R10 absent reads zero", rdata1, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R0 actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    pad_in = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    settle();
    t_reset();
    t_outputs();
    t_modes();
    t_irq();
    t_anyedge();
    t_output_pin();
    t_no_any();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule